// File: doc/BRIEF.md
# Periodic pulse output pin generator

This block drives one output pin with a programmed train of pulses or level transitions. Three quantities steer it: a mode input picks between a pulse train and a toggle train, an X word sets the base period in clock cycles, and a Y word sets how many pulses or steps are still to be emitted. An enable input arms the block. While enable is low, everything is parked. When enable goes high, a base-period timer starts, and every later period boundary is phased to that moment.

Software normally sets up the period once and then only rewrites Y to request more pulses. A new Y value never cuts into a period that is already running. It is held until the next period boundary and then replaces the remaining count. The one exception is toggle mode with a period of one cycle. There the write acts on the same clock edge that captures it. The remaining count and a done flag can be read back at all times.

Top module: `pulse_pin_gen`

## Requirements
- R1: Right after reset, pin_o is low, remain_o is zero and done_o is high.
- R2: The base-period timer begins at zero in the first cycle that en_i is high. A boundary occurs at each edge where the timer has reached the effective period minus one. The effective period is the X value, with X = 0 treated as 1.
- R3: A Y write captured at an edge with y_wr_i high starts its first pulse or step only after the first period boundary that lies strictly after that edge. This also holds at a period of 1 in pulse mode, so the first pulse appears one edge after the write.
- R4: In pulse mode (mode_i = 0), each emitted period drives pin_o high for max(1, floor(P/2)) cycles from the period start, then low for the rest of the period.
- R5: In toggle mode (mode_i = 1), pin_o inverts once at the start of each emitted period and keeps its level otherwise.
- R6: In toggle mode with an effective period of 1, a nonzero Y write toggles pin_o on the very edge that captures the write, and counts as the first step.
- R7: An X write is taken only while en_i is high. An X write while en_i is low leaves the period unchanged.
- R8: At each boundary that starts an emitted period, remain_o drops by one. done_o is high exactly when remain_o is zero and no Y write is waiting.
- R9: Y writes made between boundaries are held, and the last one wins. It replaces the remaining count only at the next boundary, even while pulses are still in progress.
- R10: While en_i is low, pin_o is low, the timer is held at zero, the count and any waiting Y value are cleared, and Y writes are discarded.
- R11: Asserting rst_ni low clears every register at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Arms the generator and starts the period timer |
| mode_i | input | 1 | 0 = pulse train, 1 = toggle train |
| x_wr_i | input | 1 | Write strobe for the period word |
| x_data_i | input | PER_W | Base period in clock cycles |
| y_wr_i | input | 1 | Write strobe for the count word |
| y_data_i | input | CNT_W | Number of pulses or steps to emit |
| pin_o | output | 1 | Generated pin level |
| remain_o | output | CNT_W | Pulses or steps still to start |
| done_o | output | 1 | Count exhausted and nothing waiting |

## Verification
The bench builds the block with PER_W = 8 and CNT_W = 8, and with the toggle variant enabled. It programs periods of 1, 3, 4 and 5. The odd period exercises the rounding of the high time. Period 1 reaches both the immediate toggle path and the one-edge wait in pulse mode. The small counts make the last-write-wins behaviour and the zero crossing of remain_o reachable within a few dozen cycles.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
   typedef enum logic {
      PG_PULSE  = 1'b0,
      PG_TOGGLE = 1'b1
   } pg_mode_e;
endpackage

// File: rtl/pgen_timer.sv
module pgen_timer #(
   parameter int PER_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             x_wr_i,
   input  logic [PER_W-1:0] x_data_i,
   output logic [PER_W-1:0] per_o,
   output logic [PER_W-1:0] timer_o,
   output logic             bnd_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] timer_q;

   // period register: written only while armed
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                per_q <= '0;
      else if (en_i && x_wr_i)    per_q <= x_data_i;
   end

   assign per_o   = (per_q == '0) ? ONE : per_q;
   assign bnd_o   = en_i && (timer_q >= per_o - ONE);
   assign timer_o = timer_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       timer_q <= '0;
      else if (!en_i)    timer_q <= '0;
      else if (bnd_o)    timer_q <= '0;
      else               timer_q <= timer_q + ONE;
   end

   // R10
   timer_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> timer_q == '0);
   // R2
   timer_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && bnd_o) |=> timer_q == '0);
endmodule

// File: rtl/pgen_counter.sv
module pgen_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             bnd_i,
   input  logic             bypass_i,
   input  logic             y_wr_i,
   input  logic [CNT_W-1:0] y_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             busy_o,
   output logic             fire_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q, pend_q, next_cnt;
   logic             pend_v_q, busy_q, imm;

   assign imm      = bypass_i && y_wr_i;
   assign next_cnt = imm ? y_data_i : (pend_v_q ? pend_q : count_q);
   assign fire_o   = bnd_i && (next_cnt != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q  <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
         busy_q   <= 1'b0;
      end else if (!en_i) begin
         count_q  <= '0;
         pend_v_q <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         if (y_wr_i) pend_q <= y_data_i;
         if (bnd_i) begin
            busy_q   <= fire_o;
            count_q  <= fire_o ? next_cnt - ONE : '0;
            pend_v_q <= y_wr_i && !imm;
         end else if (y_wr_i) begin
            pend_v_q <= 1'b1;
         end
      end
   end

   assign count_o = count_q;
   assign busy_o  = busy_q;
   assign done_o  = (count_q == '0) && !pend_v_q;

   // R9
   hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !bnd_i) |=> $stable(count_q));
   // R8
   idle_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && bnd_i && !fire_o) |=> (!busy_q && count_q == '0));
   // R6
   bypass_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && bypass_i && y_wr_i && y_data_i != '0) |=> busy_q);
endmodule

// File: rtl/pgen_shaper.sv
module pgen_shaper
   import pgen_pkg::*;
#(
   parameter int PER_W     = 16,
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  pg_mode_e         mode_i,
   input  logic             fire_i,
   input  logic             busy_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [PER_W-1:0] timer_i,
   output logic             pin_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] half, hi_len;
   logic             pulse_lvl;

   assign half      = per_i >> 1;
   assign hi_len    = (half == '0) ? ONE : half;
   assign pulse_lvl = busy_i && (timer_i < hi_len);

   generate
      if (TOGGLE_EN) begin : g_toggle
         logic tog_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                          tog_q <= 1'b0;
            else if (!en_i)                       tog_q <= 1'b0;
            else if (fire_i && mode_i == PG_TOGGLE) tog_q <= ~tog_q;
         end
         assign pin_o = (mode_i == PG_TOGGLE) ? tog_q : pulse_lvl;

         // R5
         tog_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i && !fire_i) |=> $stable(tog_q));
      end else begin : g_pulse_only
         logic unused_mode;
         assign unused_mode = (mode_i == PG_TOGGLE) ^ fire_i;
         assign pin_o = pulse_lvl;
      end
   endgenerate

   // R10
   pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !pin_o);
endmodule

// File: rtl/pulse_pin_gen.sv
module pulse_pin_gen
   import pgen_pkg::*;
#(
   parameter int PER_W     = 16,
   parameter int CNT_W     = 16,
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             mode_i,
   input  logic             x_wr_i,
   input  logic [PER_W-1:0] x_data_i,
   input  logic             y_wr_i,
   input  logic [CNT_W-1:0] y_data_i,
   output logic             pin_o,
   output logic [CNT_W-1:0] remain_o,
   output logic             done_o
);
   localparam logic [PER_W-1:0] P_ONE = PER_W'(1);

   generate
      if (PER_W < 2) begin : g_bad_per
         $error("pulse_pin_gen: PER_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("pulse_pin_gen: CNT_W must be at least 1");
      end
   endgenerate

   pg_mode_e         mode;
   logic [PER_W-1:0] per, timer;
   logic             bnd, fire, busy, bypass;

   assign mode   = pg_mode_e'(mode_i);
   assign bypass = TOGGLE_EN && (mode == PG_TOGGLE) && (per == P_ONE);

   pgen_timer #(.PER_W(PER_W)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .x_wr_i   (x_wr_i),
      .x_data_i (x_data_i),
      .per_o    (per),
      .timer_o  (timer),
      .bnd_o    (bnd)
   );

   pgen_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .bnd_i    (bnd),
      .bypass_i (bypass),
      .y_wr_i   (y_wr_i),
      .y_data_i (y_data_i),
      .count_o  (remain_o),
      .busy_o   (busy),
      .fire_o   (fire),
      .done_o   (done_o)
   );

   pgen_shaper #(.PER_W(PER_W), .TOGGLE_EN(TOGGLE_EN)) u_shaper (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .mode_i  (mode),
      .fire_i  (fire),
      .busy_i  (busy),
      .per_i   (per),
      .timer_i (timer),
      .pin_o   (pin_o)
   );
endmodule

// File: tb/pulse_pin_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_pin_gen_tb_top;
   localparam int PW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, mode = 1'b0, x_wr = 1'b0, y_wr = 1'b0;
   logic [PW-1:0] x_data = '0;
   logic [CW-1:0] y_data = '0;
   logic          pin, done;
   logic [CW-1:0] remain;

   int nchk = 0, nerr = 0, edge_n = 0;
   bit fin = 1'b0;

   always #2 clk = ~clk;

   pulse_pin_gen #(.PER_W(PW), .CNT_W(CW), .TOGGLE_EN(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
      .x_wr_i(x_wr), .x_data_i(x_data), .y_wr_i(y_wr), .y_data_i(y_data),
      .pin_o(pin), .remain_o(remain), .done_o(done));

   always @(posedge clk) edge_n <= edge_n + 1;

   // behavioural reference: integers only
   int m_per = 0, m_tim = 0, m_cnt = 0, m_pq = 0, m_pv = 0, m_busy = 0, m_tog = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_per = 0; m_tim = 0; m_cnt = 0; m_pq = 0; m_pv = 0; m_busy = 0; m_tog = 0;
      end else if (!en) begin
         m_tim = 0; m_cnt = 0; m_pv = 0; m_busy = 0; m_tog = 0;
      end else begin
         int pe, src;
         bit now_b, imm;
         pe    = (m_per == 0) ? 1 : m_per;
         now_b = (m_tim >= pe - 1);
         imm   = mode && (pe == 1) && y_wr;
         src   = imm ? int'(y_data) : (m_pv != 0 ? m_pq : m_cnt);
         if (now_b) begin
            if (src > 0) begin
               m_busy = 1; m_cnt = src - 1;
               if (mode) m_tog = 1 - m_tog;
            end else begin
               m_busy = 0; m_cnt = 0;
            end
            m_pv  = (y_wr && !imm) ? 1 : 0;
            m_tim = 0;
         end else begin
            if (y_wr) m_pv = 1;
            m_tim = m_tim + 1;
         end
         if (y_wr) m_pq = int'(y_data);
         if (x_wr) m_per = int'(x_data);
      end
   end

   function automatic int m_pin();
      int pe, hi;
      pe = (m_per == 0) ? 1 : m_per;
      hi = pe / 2;
      if (hi == 0) hi = 1;
      if (mode) return m_tog;
      return (m_busy != 0 && m_tim < hi) ? 1 : 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edge_n);
      end
   endtask

   // model comparison every cycle, 1 ns after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk("R4 R5 model pin", int'(pin), m_pin());
         chk("R8 model remain", int'(remain), m_cnt);
         chk("R8 model done", int'(done), (m_cnt == 0 && m_pv == 0) ? 1 : 0);
      end
   end

   task automatic after_edge(int t);
      while (edge_n < t) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!fin) begin
         fin = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #400000;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int e0, f0, b2, g0, tx;
      #3;
      chk("R1 reset pin", int'(pin), 0);
      chk("R1 reset remain", int'(remain), 0);
      chk("R1 reset done", int'(done), 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // pulse mode, P = 4, Y = 3
      e0 = edge_n + 1;
      en = 1'b1; x_wr = 1'b1; x_data = 8'd4;
      @(negedge clk);
      x_wr = 1'b0; y_wr = 1'b1; y_data = 8'd3;
      @(negedge clk);
      y_wr = 1'b0;
      chk("R8 done low while pending", int'(done), 0);
      for (int j = e0 + 1; j <= e0 + 18; j++) begin
         int ex;
         after_edge(j);
         ex = (j >= e0 + 4 && j < e0 + 16 && ((j - e0) % 4) < 2) ? 1 : 0;
         if (j < e0 + 4) chk("R3 wait for boundary", int'(pin), ex);
         else            chk("R4 R2 pulse shape P4", int'(pin), ex);
         if (j == e0 + 4)  chk("R8 remain after first", int'(remain), 2);
         if (j == e0 + 8)  chk("R8 remain after second", int'(remain), 1);
         if (j == e0 + 12) chk("R8 remain zero", int'(remain), 0);
      end
      after_edge(e0 + 19);
      x_wr = 1'b1; x_data = 8'd5;
      @(negedge clk);
      x_wr = 1'b0;
      after_edge(e0 + 22);
      en = 1'b0;
      after_edge(e0 + 24);
      x_wr = 1'b1; x_data = 8'd2; y_wr = 1'b1; y_data = 8'd7;
      @(negedge clk);
      x_wr = 1'b0; y_wr = 1'b0;
      chk("R10 pin low when off", int'(pin), 0);
      chk("R10 Y discarded remain", int'(remain), 0);
      chk("R10 Y discarded done", int'(done), 1);

      // re-arm, period must still be 5
      f0 = e0 + 28;
      after_edge(f0 - 1);
      en = 1'b1; y_wr = 1'b1; y_data = 8'd1;
      @(negedge clk);
      y_wr = 1'b0;
      for (int j = f0; j <= f0 + 10; j++) begin
         after_edge(j);
         chk("R7 X ignored when off P5", int'(pin), (j == f0 + 4 || j == f0 + 5) ? 1 : 0);
      end

      // rewrites
      b2 = f0 + 14;
      after_edge(b2 - 3);
      y_wr = 1'b1; y_data = 8'd5;
      @(negedge clk);
      y_wr = 1'b0;
      after_edge(b2);
      chk("R8 remain after load", int'(remain), 4);
      y_wr = 1'b1; y_data = 8'd9;
      @(negedge clk);
      y_data = 8'd3;
      @(negedge clk);
      y_wr = 1'b0;
      after_edge(b2 + 4);
      chk("R9 held until boundary", int'(remain), 4);
      after_edge(b2 + 5);
      chk("R9 last write wins", int'(remain), 2);
      after_edge(b2 + 15);
      chk("R8 zero remain", int'(remain), 0);
      chk("R8 done at zero", int'(done), 1);
      after_edge(b2 + 21);
      x_wr = 1'b1; x_data = 8'd3;
      @(negedge clk);
      x_wr = 1'b0;
      after_edge(b2 + 24);
      en = 1'b0;

      // toggle mode, P = 3, Y = 2
      g0 = b2 + 30;
      after_edge(g0 - 1);
      en = 1'b1; mode = 1'b1; y_wr = 1'b1; y_data = 8'd2;
      @(negedge clk);
      y_wr = 1'b0;
      for (int j = g0; j <= g0 + 10; j++) begin
         after_edge(j);
         chk("R5 toggle steps", int'(pin), (j >= g0 + 2 && j <= g0 + 4) ? 1 : 0);
      end

      // toggle mode, P = 1: immediate
      tx = g0 + 12;
      after_edge(tx - 1);
      x_wr = 1'b1; x_data = 8'd1;
      @(negedge clk);
      x_wr = 1'b0;
      after_edge(tx + 1);
      chk("R6 before write", int'(pin), 0);
      y_wr = 1'b1; y_data = 8'd3;
      @(negedge clk);
      y_wr = 1'b0;
      chk("R6 immediate toggle", int'(pin), 1);
      chk("R6 remain", int'(remain), 2);
      after_edge(tx + 3); chk("R6 second step", int'(pin), 0);
      after_edge(tx + 4); chk("R6 third step", int'(pin), 1);
      after_edge(tx + 6); chk("R6 hold", int'(pin), 1);

      // pulse mode, P = 1: one-edge wait
      after_edge(tx + 7);
      mode = 1'b0; y_wr = 1'b1; y_data = 8'd2;
      @(negedge clk);
      y_wr = 1'b0;
      chk("R3 P1 pulse waits", int'(pin), 0);
      after_edge(tx + 9);  chk("R4 P1 high", int'(pin), 1);
      chk("R8 P1 remain", int'(remain), 1);
      after_edge(tx + 10); chk("R4 P1 second", int'(pin), 1);
      after_edge(tx + 11); chk("R4 P1 end", int'(pin), 0);

      // asynchronous reset mid-run
      after_edge(tx + 13);
      y_wr = 1'b1; y_data = 8'd50;
      @(negedge clk);
      y_wr = 1'b0;
      after_edge(tx + 16);
      chk("R11 running before reset", int'(pin), 1);
      #1.5;
      rst_n = 1'b0;
      #0.2;
      chk("R11 async pin", int'(pin), 0);
      chk("R11 async remain", int'(remain), 0);
      chk("R11 async done", int'(done), 1);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      #2;
      finish_run();
   end
endmodule